// File: doc/BRIEF.md
# Four-Channel Serial Reset Fan-Out

This block turns reset requests written by software into the reset signals of a four-channel serial controller. Every channel has a control register with three write-one bits: one for the serial-controller reset, one for the transmit FIFO clear and one for the receive FIFO clear. A board control register carries one more bit, the board reset. The bits clear themselves, so a write is a one-time request and nothing stays latched.

A FIFO clear request becomes a single-cycle strobe on that channel's own clear output and touches nothing else. The serial controllers come two channels to a device, with channels 0 and 1 on device 0 and channels 2 and 3 on device 1. A controller reset written on either channel of a pair therefore resets that whole device. The device reset stays high for a programmable minimum of `HOLD_CYC` cycles. Each device reset is run by its own two-state machine. In state `DEV_IDLE` the output is low. The transition *trigger* moves it to `DEV_HOLD` and loads the hold counter. In `DEV_HOLD` the output is high: *retrigger* reloads the counter, *count* decrements it, and *release* (counter at zero with no trigger) returns to `DEV_IDLE`. A board reset pulses the register-default reset, strobes every FIFO clear and triggers both device machines. It is ORed over any channel request that arrives in the same cycle.

Top module: `serial_reset_fanout`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is 0.
- R2: A write (`wr_en`=1) to channel c with `wr_data[1]`=1 (transmit clear bit) drives `tx_clr[c]` high for exactly one cycle, in the cycle after the write.
- R3: A write to channel c with `wr_data[2]`=1 (receive clear bit) drives `rx_clr[c]` high for exactly one cycle, in the cycle after the write. The transmit and receive bits act independently of each other.
- R4: A FIFO clear written to channel c never asserts the FIFO clear of any other channel.
- R5: A write with `wr_data[0]`=1 (controller reset bit) to channel 2d or 2d+1 drives `ctl_rst[d]` high from the next cycle for exactly `HOLD_CYC` cycles (default 4). The other device is not affected.
- R6: A controller reset trigger that arrives while `ctl_rst[d]` is already high restarts the hold. The output then falls `HOLD_CYC` cycles after the latest trigger.
- R7: A board reset (`board_wr`=1) drives `regs_dflt` and every `tx_clr` and `rx_clr` bit high for one cycle, and both `ctl_rst` bits high for `HOLD_CYC` cycles, all starting in the cycle after the write.
- R8: A board reset takes priority over a channel write made in the same cycle. The outputs are exactly those of a board reset alone.
- R9: The request bits clear themselves. With no new write, no strobe repeats, and a write of zero bits has no effect.
- R10: When `wr_en` is 0, `wr_data` and `wr_chan` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a channel control register |
| wr_chan | input | 2 | Channel selected by the write |
| wr_data | input | 3 | Request bits: [0] controller reset, [1] transmit clear, [2] receive clear |
| board_wr | input | 1 | Board reset request |
| tx_clr | output | 4 | Per-channel transmit FIFO clear strobes |
| rx_clr | output | 4 | Per-channel receive FIFO clear strobes |
| ctl_rst | output | 2 | Per-device serial controller reset, held high |
| regs_dflt | output | 1 | One-cycle pulse that returns local registers to their defaults |

## Verification
The hardest case to reach from the ports is a second trigger that lands while a device reset is already being held. Only the timing of the fall shows whether the counter was reloaded. The stimulus starts a hold from channel 0 and then writes the sibling channel two cycles later. It checks that the output stays high until `HOLD_CYC` cycles after that second write. A full sweep over write enable, channel, all request-bit patterns and a concurrent board reset covers the pair fan-out, the FIFO isolation and the board-reset priority. The expected values for that sweep are computed arithmetically.

// File: rtl/srd_pkg.sv
package srd_pkg;
    // Request bit positions inside a channel control write
    localparam int CTL_BIT = 0;
    localparam int TX_BIT  = 1;
    localparam int RX_BIT  = 2;
    localparam int REQ_W   = 3;

    typedef enum logic {
        DEV_IDLE = 1'b0,
        DEV_HOLD = 1'b1
    } dev_state_t;
endpackage

// File: rtl/srd_fifo_strobe.sv
module srd_fifo_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic strb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb <= 1'b0;
        else        strb <= req;
    end

    p_strobe_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> strb);
    p_strobe_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> $past(req));
endmodule

// File: rtl/srd_dev_hold.sv
module srd_dev_hold
    import srd_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);
    localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC - 1);

    dev_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DEV_IDLE: begin
                if (trig) begin            // trigger
                    state_d = DEV_HOLD;
                    cnt_d   = LOAD;
                end
            end
            DEV_HOLD: begin
                if (trig) begin            // retrigger
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin  // release
                    state_d = DEV_IDLE;
                end else begin             // count
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        busy = (state_q == DEV_HOLD);
    end

    p_hold_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy);
    p_hold_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    p_release_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(trig));
endmodule

// File: rtl/serial_reset_fanout.sv
module serial_reset_fanout
    import srd_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int HOLD_CYC = 4,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int NUM_DEV = NUM_CH / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_chan,
    input  logic [REQ_W-1:0]    wr_data,
    input  logic                board_wr,
    output logic [NUM_CH-1:0]   tx_clr,
    output logic [NUM_CH-1:0]   rx_clr,
    output logic [NUM_DEV-1:0]  ctl_rst,
    output logic                regs_dflt
);
    logic [NUM_CH-1:0]  ch_sel;
    logic [NUM_CH-1:0]  tx_req, rx_req, ctl_req;
    logic [NUM_DEV-1:0] dev_trig;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_sel[c]  = wr_en && (wr_chan == CH_W'(c));
        assign tx_req[c]  = board_wr | (ch_sel[c] & wr_data[TX_BIT]);
        assign rx_req[c]  = board_wr | (ch_sel[c] & wr_data[RX_BIT]);
        assign ctl_req[c] = ch_sel[c] & wr_data[CTL_BIT];

        srd_fifo_strobe u_tx (.clk(clk), .rst_n(rst_n), .req(tx_req[c]), .strb(tx_clr[c]));
        srd_fifo_strobe u_rx (.clk(clk), .rst_n(rst_n), .req(rx_req[c]), .strb(rx_clr[c]));
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign dev_trig[d] = board_wr | ctl_req[2*d] | ctl_req[2*d+1];
        srd_dev_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
            .clk(clk), .rst_n(rst_n), .trig(dev_trig[d]), .busy(ctl_rst[d]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_dflt <= 1'b0;
        else        regs_dflt <= board_wr;
    end

    p_board_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        board_wr |=> (&tx_clr && &rx_clr && &ctl_rst && regs_dflt));
    p_dflt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_dflt |-> $past(board_wr));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !board_wr) |=> (tx_clr == '0 && rx_clr == '0 && !regs_dflt));
endmodule

// File: tb/tb_serial_reset_fanout.sv
module tb_serial_reset_fanout;
    localparam int NUM_CH = 4;
    localparam int HOLD   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [2:0] wr_data = '0;
    logic       board_wr = 1'b0;
    logic [3:0] tx_clr, rx_clr;
    logic [1:0] ctl_rst;
    logic       regs_dflt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    serial_reset_fanout #(.NUM_CH(NUM_CH), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_data(wr_data), .board_wr(board_wr), .tx_clr(tx_clr),
        .rx_clr(rx_clr), .ctl_rst(ctl_rst), .regs_dflt(regs_dflt));

    task automatic check(string req, logic [10:0] act, logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] pack_out();
        return {regs_dflt, ctl_rst, rx_clr, tx_clr};
    endfunction

    // One write, then watch HOLD+1 cycles
    task automatic apply(bit en, int ch, logic [2:0] data, bit brd, string req);
        logic [3:0] txm, rxm;
        logic [1:0] devm;
        txm = '0; rxm = '0; devm = '0;
        if (brd) begin
            txm = 4'hF; rxm = 4'hF; devm = 2'b11;
        end else if (en) begin
            if (data[1]) txm[ch] = 1'b1;
            if (data[2]) rxm[ch] = 1'b1;
            if (data[0]) devm[ch/2] = 1'b1;
        end
        @(negedge clk);
        wr_en = en; wr_chan = 2'(ch); wr_data = data; board_wr = brd;
        for (int k = 1; k <= HOLD + 1; k++) begin
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0; board_wr = 1'b0;
            check(req, pack_out(),
                  {(k == 1) ? brd : 1'b0,
                   (k <= HOLD) ? devm : 2'b00,
                   (k == 1) ? rxm : 4'h0,
                   (k == 1) ? txm : 4'h0});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", pack_out(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", pack_out(), '0);

        // Sweep: R2 R3 R4 R5 R7 R8 R9 R10
        for (int b = 0; b < 2; b++)
            for (int e = 0; e < 2; e++)
                for (int c = 0; c < NUM_CH; c++)
                    for (int d = 0; d < 8; d++)
                        apply(e[0], c, 3'(d), b[0],
                              b ? "R7/R8 board" : (e ? "R2/R3/R4/R5/R9 write" : "R10 disabled"));

        // R6: retrigger from sibling channel two cycles in
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'd0; wr_data = 3'b001;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check("R6 first hold", {9'b0, ctl_rst}, 11'b01);
        @(negedge clk);
        check("R6 first hold", {9'b0, ctl_rst}, 11'b01);
        wr_en = 1'b1; wr_chan = 2'd1; wr_data = 3'b001;
        for (int k = 1; k <= HOLD + 1; k++) begin
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0;
            check("R6 retriggered hold", {9'b0, ctl_rst}, (k <= HOLD) ? 11'b01 : 11'b00);
        end

        // R9: idle cycles, nothing repeats
        repeat (3) begin
            @(negedge clk);
            check("R9 no repeat", pack_out(), '0);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule